// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block is the host-facing front end of an enhanced parallel port. A host issues register accesses of 8, 16 or 32 bits. The block keeps the port's data and control registers and merges a sticky timeout flag into status reads. Two offsets start peripheral transfers: offset 3 starts an address cycle and offset 4 starts a data cycle. A transfer runs only when the control register holds the exact mode pattern for its direction. When it runs, the access becomes a little-endian sequence of byte transfers on a request/acknowledge handshake. Each byte has a programmable cycle limit. A missing acknowledge sets the timeout flag and abandons the rest of the access.

The block does not drive port lines itself. Data and control changes leave as one-cycle update pulses with a value. A change of the direction bit first gives its own event, and the control update follows in the next cycle. Writes that would not change a register produce no pulse. A separate window selected by `hst_ecp` answers every read with 0xFF and ignores writes.

The access machine has seven states. IDLE accepts a request. DIR_EVT pulses the direction event. CTL_PIN pulses the control update. DATA_PIN pulses the data update. XFER holds the byte request until acknowledge or expiry. STEP is the one-cycle gap between bytes. DONE returns the result. IDLE moves to DONE for plain register accesses and dropped transfers, to DATA_PIN for a changing data write, to DIR_EVT or CTL_PIN for a changing control write, and to XFER for an allowed transfer. DIR_EVT moves to CTL_PIN. CTL_PIN and DATA_PIN move to DONE. XFER moves to STEP on acknowledge and to DONE on expiry. STEP moves back to XFER while bytes remain, otherwise to DONE. DONE moves to IDLE.

Top module: `epp_port_gate`

## Requirements
- R1: After reset the data register is 0xFF, the control register reads 0xCC, the timeout flag is clear and `hst_ready` is high.
- R2: A write to offset 3 or 4 starts byte transfers only when control bits {5,3,2,1,0} (mask 0x2F) equal 0x04. Otherwise it is dropped with no handshake and no change of the timeout flag.
- R3: A read from offset 3 or 4 starts byte transfers only when the masked control bits equal 0x24. Otherwise it returns all ones over the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R4: Offset 3 transfers exactly one byte with `pp_is_addr` high. Offset 4 transfers data bytes with `pp_is_addr` low.
- R5: At offset 4, `hst_size` 0/1/2 gives 1/2/4 bytes. Byte k carries bits 8k+7:8k and byte 0 goes first. A read returns the assembled word, zero above the access width, in the single `hst_done` cycle after the last byte.
- R6: If `pp_ack` has not come after `tmo_limit` request cycles, the timeout flag sets and the remaining bytes are skipped. Read lanes that were not received return 0xFF.
- R7: The timeout flag stays set until a write to offset 1 with bit 0 = 1. An offset-1 write with bit 0 = 0 leaves it unchanged.
- R8: An offset-1 read returns `ext_status[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R9: An offset-0 write pulses `data_pin_we` with the new value only when that value differs from the stored one. An offset-0 read returns the stored value when control bit 5 is 0 and `ext_data` when it is 1.
- R10: A control write stores the written byte with bits 7:6 forced to 1. It pulses `ctl_pin_we` only when that value differs from the stored one. An offset-2 read returns the stored value.
- R11: When a control write changes bit 5, `dir_evt` pulses with `dir_val` equal to the new bit 5. `ctl_pin_we` follows in the next cycle, and `ctl_pin_val` bit 5 is cleared.
- R12: Accesses with `hst_ecp` high, and reads of offsets 5 to 7, return 0xFF. Such writes change no register.
- R13: `hst_ready` is low from acceptance until the cycle after `hst_done`, and `hst_done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tmo_limit | input | TW | Request cycles allowed per byte |
| hst_valid | input | 1 | Access request, taken when hst_ready is high |
| hst_write | input | 1 | 1 write, 0 read |
| hst_ecp | input | 1 | Selects the extended-mode stub window |
| hst_off | input | 3 | Register offset |
| hst_size | input | 2 | 0 byte, 1 half word, 2 word |
| hst_wdata | input | DW | Write data |
| hst_ready | output | 1 | Idle, may accept an access |
| hst_done | output | 1 | Access complete, hst_rdata valid |
| hst_rdata | output | DW | Read result |
| ext_status | input | 8 | Status lines from the port |
| ext_data | input | 8 | Data lines read back from the port |
| data_pin_we | output | 1 | Data line update pulse |
| data_pin_val | output | 8 | Data line value |
| ctl_pin_we | output | 1 | Control line update pulse |
| ctl_pin_val | output | 8 | Control line value |
| dir_evt | output | 1 | Direction change event |
| dir_val | output | 1 | New direction, 1 is input |
| pp_req | output | 1 | Byte transfer request |
| pp_write | output | 1 | Byte transfer direction |
| pp_is_addr | output | 1 | Address cycle when high |
| pp_wdata | output | 8 | Byte sent to the peripheral |
| pp_ack | input | 1 | Peripheral acknowledge |
| pp_rdata | input | 8 | Byte from the peripheral, taken with pp_ack |

## Verification
A wrong mode register shows up at the ports in the cycle the handshake starts. A transfer that should be dropped raises `pp_req`, or a legal one never does, and the bench sees this in the byte log before `hst_done`. A misplaced lane index or a bad byte count appears as a byte log in the wrong order, or as a read word with the wrong bytes, in the same access. A lost or spurious timeout flag stays wrong until software clears it, so the next status read shows it.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
    localparam int HOST_W = 32;

    localparam logic [2:0] OFF_DATA  = 3'd0;
    localparam logic [2:0] OFF_STAT  = 3'd1;
    localparam logic [2:0] OFF_CTRL  = 3'd2;
    localparam logic [2:0] OFF_EADDR = 3'd3;
    localparam logic [2:0] OFF_EDATA = 3'd4;

    localparam logic [7:0] CTL_FORCE = 8'hC0;
    localparam logic [7:0] CTL_DIR   = 8'h20;
    localparam logic [7:0] MODE_MASK = 8'h2F;
    localparam logic [7:0] MODE_WR   = 8'h04;
    localparam logic [7:0] MODE_RD   = 8'h24;
    localparam logic [7:0] CTL_RST   = 8'hCC;
    localparam logic [7:0] DATA_RST  = 8'hFF;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        K_SIMPLE,
        K_DATA,
        K_CTRL,
        K_EPP
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_EVT,
        ST_CTL_PIN,
        ST_DATA_PIN,
        ST_XFER,
        ST_STEP,
        ST_DONE
    } gate_state_t;
endpackage

// File: rtl/epp_access_decode.sv
module epp_access_decode
    import epp_gate_pkg::*;
#(
    parameter int DW    = HOST_W,
    parameter int LANES = DW / 8,
    parameter int NW    = $clog2(LANES + 1)
) (
    input  logic            write,
    input  logic            ecp,
    input  logic [2:0]      off,
    input  logic [1:0]      size,
    input  logic [7:0]      wbyte,
    input  logic [7:0]      data_q,
    input  logic [7:0]      ctl_q,
    input  logic            tmo_q,
    input  logic [7:1]      ext_status,
    input  logic [7:0]      ext_data,
    output acc_kind_t       kind,
    output logic [DW-1:0]   rd_val,
    output logic [NW-1:0]   nbytes,
    output logic            is_addr,
    output logic            tmo_clear,
    output logic [7:0]      new_ctl,
    output logic            dir_change
);
    logic [7:0]    forced;
    logic          mode_wr_ok;
    logic          mode_rd_ok;
    logic [NW-1:0] epp_n;
    logic [DW-1:0] ones_n;

    assign forced     = wbyte | CTL_FORCE;
    assign mode_wr_ok = (ctl_q & MODE_MASK) == MODE_WR;
    assign mode_rd_ok = (ctl_q & MODE_MASK) == MODE_RD;

    // byte count of a port access: only the data port may be wide
    always_comb begin
        epp_n = NW'(1);
        if (off == OFF_EDATA) begin
            case (size)
                2'd0:    epp_n = NW'(1);
                2'd1:    epp_n = NW'(2);
                default: epp_n = NW'(LANES);
            endcase
        end
    end

    // all-ones pattern over the access width for gated reads
    always_comb begin
        ones_n = '0;
        for (int i = 0; i < LANES; i++) begin
            if (NW'(i) < epp_n) ones_n[8*i +: 8] = 8'hFF;
        end
    end

    always_comb begin
        kind       = K_SIMPLE;
        rd_val     = '0;
        nbytes     = NW'(1);
        is_addr    = 1'b0;
        tmo_clear  = 1'b0;
        new_ctl    = ctl_q;
        dir_change = 1'b0;
        if (ecp) begin
            rd_val[7:0] = IDLE_BYTE;
        end else if (write) begin
            case (off)
                OFF_DATA: begin
                    if (wbyte != data_q) kind = K_DATA;
                end
                OFF_STAT: begin
                    tmo_clear = wbyte[0];
                end
                OFF_CTRL: begin
                    if (forced != ctl_q) begin
                        kind       = K_CTRL;
                        new_ctl    = forced;
                        dir_change = forced[5] ^ ctl_q[5];
                    end
                end
                OFF_EADDR, OFF_EDATA: begin
                    if (mode_wr_ok) begin
                        kind    = K_EPP;
                        nbytes  = epp_n;
                        is_addr = (off == OFF_EADDR);
                    end
                end
                default: ;
            endcase
        end else begin
            case (off)
                OFF_DATA:  rd_val[7:0] = ctl_q[5] ? ext_data : data_q;
                OFF_STAT:  rd_val[7:0] = {ext_status, tmo_q};
                OFF_CTRL:  rd_val[7:0] = ctl_q;
                OFF_EADDR, OFF_EDATA: begin
                    if (mode_rd_ok) begin
                        kind    = K_EPP;
                        nbytes  = epp_n;
                        is_addr = (off == OFF_EADDR);
                    end else begin
                        rd_val = ones_n;
                    end
                end
                default:   rd_val[7:0] = IDLE_BYTE;
            endcase
        end
    end
endmodule

// File: rtl/epp_byte_timer.sv
module epp_byte_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ack,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (TW+1)'(1);
    assign expire   = run && !ack && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || ack || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/epp_lane_unit.sv
module epp_lane_unit #(
    parameter int DW    = 32,
    parameter int LANES = DW / 8,
    parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1,
    parameter int NW    = $clog2(LANES + 1)
) (
    input  logic [DW-1:0] word,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    byte_in,
    input  logic [NW-1:0] nbytes,
    output logic [7:0]    byte_out,
    output logic [DW-1:0] word_ins,
    output logic [DW-1:0] keep
);
    assign byte_out = word[8*idx +: 8];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_ins[8*g +: 8] = (idx == IW'(g)) ? byte_in : word[8*g +: 8];
        assign keep[8*g +: 8]     = (NW'(g) < nbytes) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/epp_port_gate.sv
module epp_port_gate
    import epp_gate_pkg::*;
#(
    parameter int DW = HOST_W,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmo_limit,
    input  logic          hst_valid,
    input  logic          hst_write,
    input  logic          hst_ecp,
    input  logic [2:0]    hst_off,
    input  logic [1:0]    hst_size,
    input  logic [DW-1:0] hst_wdata,
    output logic          hst_ready,
    output logic          hst_done,
    output logic [DW-1:0] hst_rdata,
    input  logic [7:0]    ext_status,
    input  logic [7:0]    ext_data,
    output logic          data_pin_we,
    output logic [7:0]    data_pin_val,
    output logic          ctl_pin_we,
    output logic [7:0]    ctl_pin_val,
    output logic          dir_evt,
    output logic          dir_val,
    output logic          pp_req,
    output logic          pp_write,
    output logic          pp_is_addr,
    output logic [7:0]    pp_wdata,
    input  logic          pp_ack,
    input  logic [7:0]    pp_rdata
);
    localparam int LANES = DW / 8;
    localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int NW    = $clog2(LANES + 1);

    gate_state_t   state_q, state_d;

    logic [7:0]    data_q;
    logic [7:0]    ctl_q;
    logic [7:0]    pin_ctl_q;
    logic          tmo_q;
    logic          wr_q;
    logic          addr_q;
    logic [NW-1:0] nb_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] word_q;
    logic [DW-1:0] rdata_q;

    acc_kind_t     dec_kind;
    logic [DW-1:0] dec_rd_val;
    logic [NW-1:0] dec_nbytes;
    logic          dec_is_addr;
    logic          dec_tmo_clear;
    logic [7:0]    dec_new_ctl;
    logic          dec_dir_change;

    logic          accept;
    logic          expire;
    logic          more;
    logic [7:0]    lane_byte;
    logic [DW-1:0] word_ins;
    logic [DW-1:0] keep;

    assign accept = hst_valid && (state_q == ST_IDLE);
    assign more   = (NW'(idx_q) + NW'(1)) < nb_q;

    epp_access_decode #(.DW(DW), .LANES(LANES), .NW(NW)) u_decode (
        .write      (hst_write),
        .ecp        (hst_ecp),
        .off        (hst_off),
        .size       (hst_size),
        .wbyte      (hst_wdata[7:0]),
        .data_q     (data_q),
        .ctl_q      (ctl_q),
        .tmo_q      (tmo_q),
        .ext_status (ext_status[7:1]),
        .ext_data   (ext_data),
        .kind       (dec_kind),
        .rd_val     (dec_rd_val),
        .nbytes     (dec_nbytes),
        .is_addr    (dec_is_addr),
        .tmo_clear  (dec_tmo_clear),
        .new_ctl    (dec_new_ctl),
        .dir_change (dec_dir_change)
    );

    epp_byte_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_XFER),
        .ack    (pp_ack),
        .limit  (tmo_limit),
        .expire (expire)
    );

    epp_lane_unit #(.DW(DW), .LANES(LANES), .IW(IW), .NW(NW)) u_lanes (
        .word     (word_q),
        .idx      (idx_q),
        .byte_in  (pp_rdata),
        .nbytes   (nb_q),
        .byte_out (lane_byte),
        .word_ins (word_ins),
        .keep     (keep)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (dec_kind)
                        K_SIMPLE: state_d = ST_DONE;
                        K_DATA:   state_d = ST_DATA_PIN;
                        K_CTRL:   state_d = dec_dir_change ? ST_DIR_EVT : ST_CTL_PIN;
                        K_EPP:    state_d = ST_XFER;
                    endcase
                end
            end
            ST_DIR_EVT:  state_d = ST_CTL_PIN;
            ST_CTL_PIN:  state_d = ST_DONE;
            ST_DATA_PIN: state_d = ST_DONE;
            ST_XFER: begin
                if (pp_ack)      state_d = ST_STEP;
                else if (expire) state_d = ST_DONE;
            end
            ST_STEP:     state_d = more ? ST_XFER : ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // registers and transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= DATA_RST;
            ctl_q     <= CTL_RST;
            pin_ctl_q <= CTL_RST;
            tmo_q     <= 1'b0;
            wr_q      <= 1'b0;
            addr_q    <= 1'b0;
            nb_q      <= NW'(1);
            idx_q     <= '0;
            word_q    <= '1;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                wr_q    <= hst_write;
                addr_q  <= dec_is_addr;
                nb_q    <= dec_nbytes;
                idx_q   <= '0;
                word_q  <= hst_write ? hst_wdata : '1;
                rdata_q <= hst_write ? '0 : dec_rd_val;
                if (dec_tmo_clear) tmo_q <= 1'b0;
                if (dec_kind == K_DATA) data_q <= hst_wdata[7:0];
                if (dec_kind == K_CTRL) begin
                    ctl_q     <= dec_new_ctl;
                    pin_ctl_q <= dec_dir_change ? (dec_new_ctl & ~CTL_DIR) : dec_new_ctl;
                end
            end
            if (state_q == ST_XFER) begin
                if (pp_ack) begin
                    if (!wr_q) word_q <= word_ins;
                end else if (expire) begin
                    tmo_q   <= 1'b1;
                    rdata_q <= wr_q ? '0 : (word_q & keep);
                end
            end
            if (state_q == ST_STEP) begin
                if (more) idx_q <= idx_q + IW'(1);
                else      rdata_q <= wr_q ? '0 : (word_q & keep);
            end
        end
    end

    // outputs
    always_comb begin
        hst_ready    = (state_q == ST_IDLE);
        hst_done     = (state_q == ST_DONE);
        hst_rdata    = rdata_q;
        data_pin_we  = (state_q == ST_DATA_PIN);
        data_pin_val = data_q;
        ctl_pin_we   = (state_q == ST_CTL_PIN);
        ctl_pin_val  = pin_ctl_q;
        dir_evt      = (state_q == ST_DIR_EVT);
        dir_val      = ctl_q[5];
        pp_req       = (state_q == ST_XFER);
        pp_write     = wr_q;
        pp_is_addr   = addr_q;
        pp_wdata     = lane_byte;
    end
endmodule

// File: rtl/epp_port_gate_chk.sv
module epp_port_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hst_valid,
    input logic       hst_ready,
    input logic       hst_write,
    input logic       hst_ecp,
    input logic [2:0] hst_off,
    input logic       wdata0,
    input logic       hst_done,
    input logic       pp_req,
    input logic       pp_write,
    input logic       dir_evt,
    input logic       ctl_pin_we,
    input logic [7:0] ctl_pin_val,
    input logic [7:0] ctl_q,
    input logic       tmo_q
);
    logic clear_wr;
    assign clear_wr = hst_valid && hst_ready && hst_write && !hst_ecp &&
                      (hst_off == 3'd1) && wdata0;

    // R2
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_req && pp_write |-> (ctl_q & 8'h2F) == 8'h04);

    // R3
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_req && !pp_write |-> (ctl_q & 8'h2F) == 8'h24);

    // R13
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_req |-> !hst_ready);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done && hst_ready);

    // R11
    dir_then_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_evt |=> ctl_pin_we && !ctl_pin_val[5]);

    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q && !clear_wr |=> tmo_q);

    // R6
    tmo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_q && !pp_req |=> !tmo_q);
endmodule

bind epp_port_gate epp_port_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hst_valid   (hst_valid),
    .hst_ready   (hst_ready),
    .hst_write   (hst_write),
    .hst_ecp     (hst_ecp),
    .hst_off     (hst_off),
    .wdata0      (hst_wdata[0]),
    .hst_done    (hst_done),
    .pp_req      (pp_req),
    .pp_write    (pp_write),
    .dir_evt     (dir_evt),
    .ctl_pin_we  (ctl_pin_we),
    .ctl_pin_val (ctl_pin_val),
    .ctl_q       (ctl_q),
    .tmo_q       (tmo_q)
);

// File: tb/epp_port_gate_bench.sv
module epp_port_gate_bench;
    localparam int DW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmo_limit = 8'd4;
    logic          hst_valid = 1'b0;
    logic          hst_write = 1'b0;
    logic          hst_ecp = 1'b0;
    logic [2:0]    hst_off = '0;
    logic [1:0]    hst_size = '0;
    logic [DW-1:0] hst_wdata = '0;
    logic          hst_ready, hst_done;
    logic [DW-1:0] hst_rdata;
    logic [7:0]    ext_status = 8'h5A;
    logic [7:0]    ext_data = 8'h96;
    logic          data_pin_we, ctl_pin_we, dir_evt, dir_val;
    logic [7:0]    data_pin_val, ctl_pin_val;
    logic          pp_req, pp_write, pp_is_addr;
    logic [7:0]    pp_wdata;
    logic          pp_ack = 1'b0;
    logic [7:0]    pp_rdata = '0;

    always #5 clk = ~clk;

    epp_port_gate #(.DW(DW), .TW(TW)) u_epp_port_gate (.*);

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        bit          cmp;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    int done_cnt = 0;

    // peripheral log: {write, is_addr, byte}
    logic [9:0] plog[$];
    int  ack_budget = 1000;
    int  ack_dly = 1;
    int  pcnt = 0;
    logic [7:0] rd_base = 8'h00;
    int  rd_idx = 0;

    int cyc = 0;
    int dir_t = -10, ctl_t = -10;
    int dir_seen = 0, ctl_seen = 0, dat_seen = 0;
    logic dir_v;
    logic [7:0] ctl_v, dat_v;
    int busy_viol = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // peripheral model
    always @(negedge clk) begin
        if (pp_ack) begin
            pp_ack = 1'b0;
        end else if (pp_req && ack_budget > 0) begin
            pcnt++;
            if (pcnt >= ack_dly) begin
                pcnt = 0;
                ack_budget--;
                if (!pp_write) begin
                    pp_rdata = rd_base + 8'(rd_idx);
                    rd_idx++;
                end
                plog.push_back({pp_write, pp_is_addr, pp_write ? pp_wdata : pp_rdata});
                pp_ack = 1'b1;
            end
        end else begin
            pcnt = 0;
        end
    end

    // pin event monitor and busy monitor
    always @(negedge clk) begin
        cyc++;
        if (dir_evt)     begin dir_t = cyc; dir_seen++; dir_v = dir_val; end
        if (ctl_pin_we)  begin ctl_t = cyc; ctl_seen++; ctl_v = ctl_pin_val; end
        if (data_pin_we) begin dat_seen++; dat_v = data_pin_val; end
        if (pp_req && hst_ready) busy_viol++;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && hst_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R13 unexpected done", hst_rdata, 32'h0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.cmp) chk(hst_rdata === it.exp, it.tag, hst_rdata, it.exp);
            end
            done_cnt++;
        end
    end

    task automatic access(input bit wr, input bit ecp, input logic [2:0] off,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] exp, input string tag);
        sb_item_t it;
        int start;
        @(negedge clk);
        while (!hst_ready) @(negedge clk);
        it.cmp = !wr; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        start = done_cnt;
        hst_valid = 1'b1; hst_write = wr; hst_ecp = ecp;
        hst_off = off; hst_size = sz; hst_wdata = wd;
        @(negedge clk);
        hst_valid = 1'b0;
        while (done_cnt == start) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        access(1'b0, 1'b0, off, sz, 32'h0, exp, tag);
    endtask

    task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] wd);
        access(1'b1, 1'b0, off, sz, wd, 32'h0, "write");
    endtask

    initial begin
        int n0, c0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hst_ready === 1'b1, "R1 ready after reset", {31'h0, hst_ready}, 32'h1);
        rd(3'd2, 2'd0, 32'hCC, "R1 control reset");
        rd(3'd0, 2'd0, 32'hFF, "R1 data reset");
        ext_status = 8'h5B;
        rd(3'd1, 2'd0, 32'h5A, "R8 status bit0 replaced by clear flag");

        // gated off in reset mode (0xCC)
        n0 = plog.size();
        wr(3'd4, 2'd2, 32'hDEADBEEF);
        chk(plog.size() == n0, "R2 write dropped in wrong mode", plog.size(), n0);
        rd(3'd4, 2'd0, 32'h000000FF, "R3 gated byte read");
        rd(3'd4, 2'd1, 32'h0000FFFF, "R3 gated half read");
        rd(3'd4, 2'd2, 32'hFFFFFFFF, "R3 gated word read");
        rd(3'd1, 2'd0, 32'h5A, "R2 gated access leaves timeout clear");

        // write mode
        c0 = ctl_seen;
        wr(3'd2, 2'd0, 32'h04);
        chk(ctl_seen == c0 + 1 && ctl_v == 8'hC4, "R10 control pin update", ctl_v, 8'hC4);
        chk(dir_seen == 0, "R11 no dir event without change", dir_seen, 0);
        rd(3'd2, 2'd0, 32'hC4, "R10 control forced bits");

        n0 = plog.size();
        wr(3'd3, 2'd0, 32'h0000003A);
        chk(plog.size() == n0 + 1 && plog[n0] == {2'b11, 8'h3A}, "R4 address write byte",
            plog[n0], {2'b11, 8'h3A});
        n0 = plog.size();
        wr(3'd4, 2'd2, 32'h11223344);
        chk(plog.size() == n0 + 4, "R5 word write byte count", plog.size(), n0 + 4);
        chk(plog[n0] == {2'b10, 8'h44} && plog[n0+1] == {2'b10, 8'h33} &&
            plog[n0+2] == {2'b10, 8'h22} && plog[n0+3] == {2'b10, 8'h11},
            "R5 word write little-endian order", {plog[n0][7:0], plog[n0+3][7:0]}, 16'h4411);
        n0 = plog.size();
        ack_dly = 3;
        wr(3'd4, 2'd1, 32'h0000BEEF);
        ack_dly = 1;
        chk(plog.size() == n0 + 2 && plog[n0] == {2'b10, 8'hEF} && plog[n0+1] == {2'b10, 8'hBE},
            "R5 half write", {plog[n0][7:0], plog[n0+1][7:0]}, 16'hEFBE);
        rd(3'd4, 2'd0, 32'h000000FF, "R3 read gated in write mode");

        // direction change into read mode
        c0 = ctl_seen;
        wr(3'd2, 2'd0, 32'h24);
        chk(dir_seen == 1 && dir_v == 1'b1, "R11 dir event value", {31'h0, dir_v}, 32'h1);
        chk(ctl_seen == c0 + 1 && ctl_t == dir_t + 1, "R11 control pin one cycle after dir event",
            ctl_t - dir_t, 1);
        chk(ctl_v == 8'hC4, "R11 pin value with dir masked", ctl_v, 8'hC4);
        rd(3'd2, 2'd0, 32'hE4, "R10 control read in read mode");
        rd(3'd0, 2'd0, 32'h96, "R9 data read follows ext lines when direction is input");

        n0 = plog.size();
        wr(3'd4, 2'd0, 32'h77);
        chk(plog.size() == n0, "R2 write dropped in read mode", plog.size(), n0);

        rd_base = 8'hA0; rd_idx = 0;
        rd(3'd4, 2'd2, 32'hA3A2A1A0, "R5 word read assembled");
        rd_base = 8'h30; rd_idx = 0;
        rd(3'd4, 2'd1, 32'h00003130, "R5 half read assembled");
        rd_base = 8'h7C; rd_idx = 0;
        n0 = plog.size();
        rd(3'd3, 2'd2, 32'h0000007C, "R4 address read one byte");
        chk(plog.size() == n0 + 1 && plog[n0] == {2'b01, 8'h7C}, "R4 address read flag",
            plog[n0], {2'b01, 8'h7C});

        // timeout partway through a word read
        rd_base = 8'h50; rd_idx = 0; ack_budget = 2;
        n0 = plog.size();
        rd(3'd4, 2'd2, 32'hFFFF5150, "R6 partial read after timeout");
        chk(plog.size() == n0 + 2, "R6 remaining bytes abandoned", plog.size(), n0 + 2);
        ack_budget = 1000;
        ext_status = 8'h5A;
        rd(3'd1, 2'd0, 32'h5B, "R8 status shows timeout flag");
        wr(3'd1, 2'd0, 32'hFE);
        rd(3'd1, 2'd0, 32'h5B, "R7 flag kept on write with bit0 clear");
        rd_base = 8'h10; rd_idx = 0;
        rd(3'd4, 2'd0, 32'h10, "R7 good transfer keeps flag");
        rd(3'd1, 2'd0, 32'h5B, "R7 flag still set after good transfer");
        wr(3'd1, 2'd0, 32'h01);
        rd(3'd1, 2'd0, 32'h5A, "R7 flag cleared");

        // redundant writes
        d0 = dat_seen;
        wr(3'd0, 2'd0, 32'hFF);
        chk(dat_seen == d0, "R9 equal data write gives no pin update", dat_seen, d0);
        wr(3'd0, 2'd0, 32'h55);
        chk(dat_seen == d0 + 1 && dat_v == 8'h55, "R9 data pin update", dat_v, 8'h55);
        wr(3'd0, 2'd0, 32'h55);
        chk(dat_seen == d0 + 1, "R9 repeated data write ignored", dat_seen, d0 + 1);
        c0 = ctl_seen;
        wr(3'd2, 2'd0, 32'h24);
        wr(3'd2, 2'd0, 32'hE4);
        chk(ctl_seen == c0 && dir_seen == 1, "R10 redundant control write ignored", ctl_seen, c0);

        // stub window and unused offsets
        access(1'b0, 1'b1, 3'd0, 2'd0, 32'h0, 32'hFF, "R12 stub window read");
        access(1'b1, 1'b1, 3'd2, 2'd0, 32'h00, 32'h0, "write");
        rd(3'd2, 2'd0, 32'hE4, "R12 stub window write ignored");
        rd(3'd6, 2'd0, 32'hFF, "R12 unused offset read");

        chk(busy_viol == 0, "R13 ready low during transfer", busy_viol, 0);
        chk(sb_q.size() == 0, "R13 every access completed", sb_q.size(), 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule